// File: doc/BRIEF.md
# Interlaced Raster Timing Generator

This block produces the raster timing for a display pipeline: a pixel counter, a line counter, a horizontal sync, a vertical sync, a composite sync, a data-enable strobe, a frame-start strobe and a field identifier. It runs on the pixel clock. One pixel position is consumed per clock. Pixel clock generation, pixel fetch, scaling and colour handling are outside the block.

The display mode is presented on a flat configuration port. The port carries the active width and height, the line and frame totals, the sync start and end positions, one polarity inversion per sync output and an interlace enable. The block copies the configuration into a working set only while reset is held and on the last pixel of a frame. A mode change therefore never produces a partial frame.

In interlaced mode the block alternates between two fields. Field 0 is the long field: it has one extra line, and its vertical sync starts and ends one line later and half a line earlier in the line. Field 1 uses the programmed values unchanged, and so does progressive mode.

Top module: `raster_timing_gen`

## Requirements
- R1: `hcount` runs 0 to `cfg_htot`-1. At the last pixel of a line it wraps to 0 and `vcount` advances. At the last pixel of the last line of the current field both counters return to 0. Reset holds both counters at 0. `frame_start` is 1 exactly when both counters are 0.
- R2: `de` is 1 exactly when `hcount` < `cfg_hact` and `vcount` < `cfg_vact`.
- R3: Before inversion, horizontal sync is 1 when `cfg_hs_start` <= `hcount` < `cfg_hs_end`.
- R4: In progressive mode, and in field 1, vertical sync before inversion is 1 from raster position (line `cfg_vs_start`, pixel `cfg_hs_start`) inclusive to (line `cfg_vs_end`, pixel `cfg_hs_start`) exclusive, in raster order. The frame has `cfg_vtot` lines.
- R5: In interlaced mode, field 0 has `cfg_vtot`+1 lines. Its vertical sync window runs from line `cfg_vs_start`+1 to line `cfg_vs_end`+1, and both edges fall at pixel `cfg_hs_start` - `cfg_htot`/2 (this requires `cfg_hs_start` >= `cfg_htot`/2).
- R6: `field` is 0 after reset and is held at 0 while the working mode is progressive. At a frame boundary where the newly captured mode is interlaced, `field` toggles. At a boundary into progressive mode it returns to 0.
- R7: Each of `hsync`, `vsync` and `csync` is inverted when its own inversion bit is 1 and is active-high when the bit is 0. Composite sync before inversion is horizontal sync OR vertical sync.
- R8: Configuration changes applied in the middle of a frame have no effect until the first pixel of the next frame. At that point every configuration field takes effect together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high; captures the configuration |
| cfg_hact | input | 12 | Active pixels per line |
| cfg_htot | input | 12 | Total pixels per line |
| cfg_hs_start | input | 12 | First pixel of horizontal sync |
| cfg_hs_end | input | 12 | Pixel after the last pixel of horizontal sync |
| cfg_vact | input | 11 | Active lines per frame |
| cfg_vtot | input | 11 | Total lines of the progressive frame or short field |
| cfg_vs_start | input | 11 | First line of vertical sync |
| cfg_vs_end | input | 11 | Line on which vertical sync ends |
| cfg_hs_inv | input | 1 | Invert horizontal sync |
| cfg_vs_inv | input | 1 | Invert vertical sync |
| cfg_cs_inv | input | 1 | Invert composite sync |
| cfg_ilace | input | 1 | Interlace enable |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| csync | output | 1 | Composite sync |
| de | output | 1 | Data enable |
| field | output | 1 | Field identifier |
| frame_start | output | 1 | First pixel of a frame or field |
| hcount | output | 12 | Pixel counter |
| vcount | output | 11 | Line counter |

## Verification
The bench builds the block with its default 12-bit pixel and 11-bit line counters. It drives a tiny mode: lines of 20 and then 16 pixels, and 9 or 10 lines per field. Every pixel of every frame can therefore be compared against an arithmetic model in a few thousand cycles. This covers both field variants and the half-line vertical sync offset at two different line lengths. It also covers mid-frame mode changes together with the moves into and out of interlace, and every polarity combination used.

// File: rtl/rtg_pkg.sv
package rtg_pkg;
  localparam int unsigned HCW = 12;
  localparam int unsigned VCW = 11;

  typedef struct packed {
    logic [HCW-1:0] hact;
    logic [HCW-1:0] htot;
    logic [HCW-1:0] hs_start;
    logic [HCW-1:0] hs_end;
    logic [VCW-1:0] vact;
    logic [VCW-1:0] vtot;
    logic [VCW-1:0] vs_start;
    logic [VCW-1:0] vs_end;
    logic           hs_inv;
    logic           vs_inv;
    logic           cs_inv;
    logic           ilace;
  } mode_t;

  // lines in the current field: the long field carries one extra line
  function automatic logic [VCW-1:0] field_lines(logic [VCW-1:0] vtot, logic long_f);
    return vtot + {{(VCW-1){1'b0}}, long_f};
  endfunction

  // line index shifted by one in the long field
  function automatic logic [VCW-1:0] field_line(logic [VCW-1:0] ln, logic long_f);
    return ln + {{(VCW-1){1'b0}}, long_f};
  endfunction

  // pixel at which vertical sync changes: half a line earlier in the long field
  function automatic logic [HCW-1:0] vs_pixel(logic [HCW-1:0] hs_start,
                                              logic [HCW-1:0] htot, logic long_f);
    return long_f ? hs_start - (htot >> 1) : hs_start;
  endfunction

  // raster position (v,h) is at or after (vl,hp)
  function automatic logic at_or_after(logic [VCW-1:0] v, logic [HCW-1:0] h,
                                       logic [VCW-1:0] vl, logic [HCW-1:0] hp);
    return (v > vl) || ((v == vl) && (h >= hp));
  endfunction
endpackage

// File: rtl/rtg_mode_hold.sv
module rtg_mode_hold
  import rtg_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  mode_t cfg,
  input  logic  frame_end,
  output mode_t cur,
  output logic  field,
  output logic  long_f
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cur   <= cfg;
      field <= 1'b0;
    end else if (frame_end) begin
      cur   <= cfg;
      field <= cfg.ilace ? ~field : 1'b0;
    end
  end

  assign long_f = cur.ilace & ~field;

  // R8: working mode only moves at a frame boundary
  a_r8_mode_held: assert property (@(posedge clk) disable iff (rst)
    !frame_end |=> $stable(cur));
  // R6: progressive keeps field at 0
  a_r6_prog_field: assert property (@(posedge clk) disable iff (rst)
    !cur.ilace |-> !field);
  // R6: interlaced boundary flips the field
  a_r6_field_flip: assert property (@(posedge clk) disable iff (rst)
    (frame_end && cfg.ilace) |=> (field != $past(field)));
endmodule

// File: rtl/rtg_raster_cnt.sv
module rtg_raster_cnt #(
  parameter int unsigned HW = 12,
  parameter int unsigned VW = 11
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [HW-1:0] htot,
  input  logic [VW-1:0] vlines,
  output logic [HW-1:0] hcount,
  output logic [VW-1:0] vcount,
  output logic          line_end,
  output logic          frame_end
);
  localparam logic [HW-1:0] H_ONE = 1;
  localparam logic [VW-1:0] V_ONE = 1;

  assign line_end  = (hcount == htot - H_ONE);
  assign frame_end = line_end && (vcount == vlines - V_ONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      hcount <= '0;
      vcount <= '0;
    end else begin
      hcount <= line_end ? '0 : hcount + H_ONE;
      if (line_end) vcount <= frame_end ? '0 : vcount + V_ONE;
    end
  end

  // R1: pixel counter steps and wraps
  a_r1_h_wrap: assert property (@(posedge clk) disable iff (rst)
    line_end |=> (hcount == '0));
  a_r1_h_step: assert property (@(posedge clk) disable iff (rst)
    !line_end |=> (hcount == $past(hcount) + H_ONE));
  // R1: line counter holds inside a line and clears at frame end
  a_r1_v_hold: assert property (@(posedge clk) disable iff (rst)
    !line_end |=> $stable(vcount));
  a_r1_v_wrap: assert property (@(posedge clk) disable iff (rst)
    frame_end |=> (vcount == '0));
endmodule

// File: rtl/rtg_sync_decode.sv
module rtg_sync_decode #(
  parameter int unsigned HW = 12,
  parameter int unsigned VW = 11
) (
  input  logic [HW-1:0] hcount,
  input  logic [VW-1:0] vcount,
  input  logic [HW-1:0] hact,
  input  logic [VW-1:0] vact,
  input  logic [HW-1:0] hs_start,
  input  logic [HW-1:0] hs_end,
  input  logic [VW-1:0] vs_line0,
  input  logic [VW-1:0] vs_line1,
  input  logic [HW-1:0] vs_hpos,
  input  logic          hs_inv,
  input  logic          vs_inv,
  input  logic          cs_inv,
  output logic          hs_raw,
  output logic          vs_raw,
  output logic          hsync,
  output logic          vsync,
  output logic          csync,
  output logic          de
);
  import rtg_pkg::at_or_after;

  always_comb begin
    hs_raw = (hcount >= hs_start) && (hcount < hs_end);
    vs_raw = at_or_after(vcount, hcount, vs_line0, vs_hpos) &&
             !at_or_after(vcount, hcount, vs_line1, vs_hpos);
    de     = (hcount < hact) && (vcount < vact);
    hsync  = hs_raw ^ hs_inv;
    vsync  = vs_raw ^ vs_inv;
    csync  = (hs_raw | vs_raw) ^ cs_inv;
  end
endmodule

// File: rtl/raster_timing_gen.sv
module raster_timing_gen
  import rtg_pkg::*;
(
  input  logic           clk,
  input  logic           rst,
  input  logic [HCW-1:0] cfg_hact,
  input  logic [HCW-1:0] cfg_htot,
  input  logic [HCW-1:0] cfg_hs_start,
  input  logic [HCW-1:0] cfg_hs_end,
  input  logic [VCW-1:0] cfg_vact,
  input  logic [VCW-1:0] cfg_vtot,
  input  logic [VCW-1:0] cfg_vs_start,
  input  logic [VCW-1:0] cfg_vs_end,
  input  logic           cfg_hs_inv,
  input  logic           cfg_vs_inv,
  input  logic           cfg_cs_inv,
  input  logic           cfg_ilace,
  output logic           hsync,
  output logic           vsync,
  output logic           csync,
  output logic           de,
  output logic           field,
  output logic           frame_start,
  output logic [HCW-1:0] hcount,
  output logic [VCW-1:0] vcount
);
  mode_t          cfg_in;
  mode_t          cur;
  logic           long_f;
  logic           line_end;
  logic           frame_end;
  logic           hs_raw;
  logic           vs_raw;
  logic [VCW-1:0] vlines;
  logic [VCW-1:0] vs_line0;
  logic [VCW-1:0] vs_line1;
  logic [HCW-1:0] vs_hpos;

  assign cfg_in = '{hact: cfg_hact, htot: cfg_htot, hs_start: cfg_hs_start,
                    hs_end: cfg_hs_end, vact: cfg_vact, vtot: cfg_vtot,
                    vs_start: cfg_vs_start, vs_end: cfg_vs_end,
                    hs_inv: cfg_hs_inv, vs_inv: cfg_vs_inv,
                    cs_inv: cfg_cs_inv, ilace: cfg_ilace};

  rtg_mode_hold u_mode (
    .clk(clk), .rst(rst), .cfg(cfg_in), .frame_end(frame_end),
    .cur(cur), .field(field), .long_f(long_f)
  );

  assign vlines   = field_lines(cur.vtot, long_f);
  assign vs_line0 = field_line(cur.vs_start, long_f);
  assign vs_line1 = field_line(cur.vs_end, long_f);
  assign vs_hpos  = vs_pixel(cur.hs_start, cur.htot, long_f);

  rtg_raster_cnt #(.HW(HCW), .VW(VCW)) u_cnt (
    .clk(clk), .rst(rst), .htot(cur.htot), .vlines(vlines),
    .hcount(hcount), .vcount(vcount), .line_end(line_end), .frame_end(frame_end)
  );

  rtg_sync_decode #(.HW(HCW), .VW(VCW)) u_dec (
    .hcount(hcount), .vcount(vcount), .hact(cur.hact), .vact(cur.vact),
    .hs_start(cur.hs_start), .hs_end(cur.hs_end),
    .vs_line0(vs_line0), .vs_line1(vs_line1), .vs_hpos(vs_hpos),
    .hs_inv(cur.hs_inv), .vs_inv(cur.vs_inv), .cs_inv(cur.cs_inv),
    .hs_raw(hs_raw), .vs_raw(vs_raw),
    .hsync(hsync), .vsync(vsync), .csync(csync), .de(de)
  );

  assign frame_start = (hcount == '0) && (vcount == '0);

  // R4/R5: vertical sync edges land on the field's sync pixel
  a_r5_vs_rise_pixel: assert property (@(posedge clk) disable iff (rst)
    $rose(vs_raw) |-> (hcount == vs_hpos));
  a_r5_vs_fall_pixel: assert property (@(posedge clk) disable iff (rst)
    $fell(vs_raw) |-> (hcount == vs_hpos));
  // R7: composite sync follows horizontal sync while it is active
  a_r7_cs_follows_hs: assert property (@(posedge clk) disable iff (rst)
    hs_raw |-> (csync == !cur.cs_inv));
endmodule

// File: tb/tb_raster_timing_gen.sv
`timescale 1ns/1ps
module tb_raster_timing_gen;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic [11:0] cfg_hact, cfg_htot, cfg_hs_start, cfg_hs_end;
  logic [10:0] cfg_vact, cfg_vtot, cfg_vs_start, cfg_vs_end;
  logic cfg_hs_inv, cfg_vs_inv, cfg_cs_inv, cfg_ilace;
  logic hsync, vsync, csync, de, field, frame_start;
  logic [11:0] hcount;
  logic [10:0] vcount;

  raster_timing_gen dut (
    .clk(clk), .rst(rst),
    .cfg_hact(cfg_hact), .cfg_htot(cfg_htot), .cfg_hs_start(cfg_hs_start),
    .cfg_hs_end(cfg_hs_end), .cfg_vact(cfg_vact), .cfg_vtot(cfg_vtot),
    .cfg_vs_start(cfg_vs_start), .cfg_vs_end(cfg_vs_end),
    .cfg_hs_inv(cfg_hs_inv), .cfg_vs_inv(cfg_vs_inv), .cfg_cs_inv(cfg_cs_inv),
    .cfg_ilace(cfg_ilace),
    .hsync(hsync), .vsync(vsync), .csync(csync), .de(de), .field(field),
    .frame_start(frame_start), .hcount(hcount), .vcount(vcount)
  );

  int errors = 0;
  int checks = 0;
  bit done = 0;

  // bench model of the working mode and raster position
  int m_hact, m_htot, m_hss, m_hse, m_vact, m_vtot, m_vss, m_vse;
  int m_hinv, m_vinv, m_cinv, m_il;
  int mh, mv, mfield;
  int since_start, last_len;
  bit have_start;

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic capture();
    m_hact = cfg_hact; m_htot = cfg_htot; m_hss = cfg_hs_start; m_hse = cfg_hs_end;
    m_vact = cfg_vact; m_vtot = cfg_vtot; m_vss = cfg_vs_start; m_vse = cfg_vs_end;
    m_hinv = cfg_hs_inv; m_vinv = cfg_vs_inv; m_cinv = cfg_cs_inv; m_il = cfg_ilace;
  endtask

  function automatic int is_long();
    return (m_il != 0 && mfield == 0) ? 1 : 0;
  endfunction

  task automatic compare();
    int lg, pos, p0, p1, hp, ehs, evs, ede;
    lg  = is_long();
    hp  = (lg != 0) ? m_hss - m_htot / 2 : m_hss;
    pos = mv * m_htot + mh;
    p0  = (m_vss + lg) * m_htot + hp;
    p1  = (m_vse + lg) * m_htot + hp;
    ehs = (mh >= m_hss && mh < m_hse) ? 1 : 0;
    evs = (pos >= p0 && pos < p1) ? 1 : 0;
    ede = (mh < m_hact && mv < m_vact) ? 1 : 0;
    chk(hcount == mh, "R1", "hcount", hcount, mh);
    chk(vcount == mv, "R1", "vcount", vcount, mv);
    chk(frame_start == (mh == 0 && mv == 0), "R1", "frame_start", frame_start, (mh == 0 && mv == 0));
    chk(de == ede, "R2", "de", de, ede);
    chk(hsync == (ehs ^ m_hinv), "R3", "hsync", hsync, ehs ^ m_hinv);
    chk(vsync == (evs ^ m_vinv), (lg != 0) ? "R5" : "R4", "vsync", vsync, evs ^ m_vinv);
    chk(csync == ((ehs | evs) ^ m_cinv), "R7", "csync", csync, (ehs | evs) ^ m_cinv);
    chk(field == mfield, "R6", "field", field, mfield);
  endtask

  // one pixel: model advances as the design does at the edge, then compare
  task automatic tick();
    int vt;
    vt = m_vtot + is_long();
    if (mh == m_htot - 1) begin
      mh = 0;
      if (mv == vt - 1) begin
        mv = 0;
        capture();
        mfield = (m_il != 0) ? 1 - mfield : 0;
      end else mv++;
    end else mh++;
    @(negedge clk);
    compare();
    since_start++;
    if (frame_start) begin
      if (have_start)
        chk(since_start == last_len, "R5", "frame length", since_start, last_len);
      have_start = 1;
      since_start = 0;
      last_len = (m_vtot + is_long()) * m_htot;
    end
  endtask

  task automatic run_frames(int n);
    int seen;
    seen = 0;
    while (seen < n) begin
      tick();
      if (frame_start) seen++;
    end
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : stim
    bit saw_old;
    cfg_hact = 12; cfg_htot = 20; cfg_hs_start = 14; cfg_hs_end = 17;
    cfg_vact = 5;  cfg_vtot = 9;  cfg_vs_start = 6;  cfg_vs_end = 8;
    cfg_hs_inv = 0; cfg_vs_inv = 0; cfg_cs_inv = 0; cfg_ilace = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(hcount == 0 && vcount == 0, "R1", "counters in reset", hcount, 0);
    chk(field == 0, "R6", "field in reset", field, 0);
    capture();
    mh = 0; mv = 0; mfield = 0; since_start = 0; have_start = 0; last_len = 0;
    rst = 1'b0;
    compare();
    have_start = 1; last_len = 9 * 20;

    // progressive frames
    run_frames(2);

    // mid-frame change: shorter line, inverted hsync, interlace on (R8)
    repeat (90) tick();
    cfg_htot = 16; cfg_hs_end = 15; cfg_hs_inv = 1; cfg_ilace = 1;
    saw_old = 0;
    while (!frame_start) begin
      tick();
      if (!frame_start && hcount >= 16) saw_old = 1;
    end
    chk(saw_old, "R8", "old line length kept until frame end", saw_old, 1);
    chk(hsync == 1'b1, "R8", "new polarity at frame start", hsync, 1);
    chk(field == 1'b1, "R6", "first interlaced field", field, 1);

    // interlaced fields at 16-pixel lines
    run_frames(4);

    // all polarities inverted, 20-pixel lines, still interlaced
    cfg_htot = 20; cfg_hs_end = 17; cfg_vs_inv = 1; cfg_cs_inv = 1;
    run_frames(5);

    // back to progressive with mixed polarity
    cfg_ilace = 0; cfg_hs_inv = 0; cfg_vs_inv = 1; cfg_cs_inv = 0;
    run_frames(3);
    chk(field == 1'b0, "R6", "field after leaving interlace", field, 0);

    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule